// File: doc/BRIEF.md
# Rotate-Mask Shift Unit with MQ

This block is the execution slice for one fixed-point instruction of a 32-bit processor: shift left with a side quotient register. It decodes a 32-bit instruction word, takes a source operand and a shift-control operand from the register file, and rotates the source left by the low five bits of the control operand. The full rotated word always lands in a dedicated MQ register held inside the block. The destination register receives the rotated word ANDed with a mask. When bit 5 of the control operand is clear, the mask makes the result a true left shift. When that bit is set, the mask is all zeros.

When the instruction's record bit is set, the block also rewrites its condition field 0. That field holds a signed less-than, greater-than or equal-to-zero test of the destination result, plus a copy of the summary-overflow bit supplied from outside. The block never writes the exception register and raises no overflow. All results are registered on the clock edge where a valid, matching instruction is presented. The register-file read indices are decoded straight from the instruction word.

Top module: `slq_unit`

## Requirements
- R1: An instruction is accepted only when instr_i[31:26] equals 31 and instr_i[10:1] equals 152 (bit 0 of big-endian numbering is instr_i[31]); otherwise no write enable rises and mq_o and cr0_o keep their values.
- R2: One cycle after an accepted instruction, mq_o holds rs_val_i rotated left by rb_val_i[4:0], whatever rb_val_i[5] is.
- R3: With rb_val_i[5] = 0, ra_data_o holds the rotated word ANDed with a mask whose bits at LSB positions N and above are one and whose lower N bits are zero, N = rb_val_i[4:0].
- R4: With rb_val_i[5] = 1, ra_data_o is zero.
- R5: ra_we_o is a one-cycle pulse in the cycle after each accepted instruction, with ra_idx_o = instr_i[20:16] from that instruction.
- R6: When the accepted instruction has instr_i[0] = 1, cr0_we_o pulses and cr0_o becomes {LT, GT, EQ, SO} (bit 3 down to bit 0) from a signed compare of the result with zero, SO copied from sum_ovf_i.
- R7: When instr_i[0] = 0, cr0_we_o stays low and cr0_o is unchanged.
- R8: After reset, mq_o, cr0_o, ra_data_o, ra_idx_o and all write enables are zero.
- R9: Bits 31:6 of rb_val_i have no effect on any result.
- R10: rs_idx_o = instr_i[25:21] and rb_idx_o = instr_i[15:11] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Source operand value |
| rb_val_i | input | 32 | Shift-control operand value |
| sum_ovf_i | input | 1 | Summary-overflow bit from the exception register |
| rs_idx_o | output | 5 | Source register read index |
| rb_idx_o | output | 5 | Shift-control register read index |
| ra_we_o | output | 1 | Destination write enable |
| ra_idx_o | output | 5 | Destination register index |
| ra_data_o | output | 32 | Masked result |
| mq_o | output | 32 | MQ register contents |
| cr0_we_o | output | 1 | Condition field 0 written |
| cr0_o | output | 4 | Condition field 0: LT, GT, EQ, SO |

## Verification
The assertions assume that rst_ni is held low for at least one clock edge and that valid_i, instr_i and the operands are stable around each rising edge. They also assume that the operands carry no unknown bits while valid_i is high. The bench changes all inputs only on falling edges and always drives fully defined values, with valid_i low between operations. Random instruction words are built either with the matching opcode fields or with deliberately wrong ones. Random rb_val_i values have set upper bits, so the ignored-bits and the kill-mask cases arise both randomly and in directed form.

// File: rtl/slq_pkg.sv
package slq_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned PRIM_OPC = 31;
  localparam int unsigned EXT_OPC  = 152;
  localparam int unsigned CR_W     = 4;

  typedef struct packed {
    logic             hit;
    logic             rec;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] dst_idx;
    logic [IDX_W-1:0] ctl_idx;
  } dec_t;
endpackage

// File: rtl/slq_decode.sv
module slq_decode
  import slq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [5:0] prim;
  logic [9:0] ext;

  // big-endian bit k maps to instr_i[31-k]
  assign prim            = instr_i[31:26];
  assign ext             = instr_i[10:1];
  assign dec_o.hit       = (prim == 6'(PRIM_OPC)) && (ext == 10'(EXT_OPC));
  assign dec_o.rec       = instr_i[0];
  assign dec_o.src_idx   = instr_i[25:21];
  assign dec_o.dst_idx   = instr_i[20:16];
  assign dec_o.ctl_idx   = instr_i[15:11];
endmodule

// File: rtl/slq_rotl.sv
module slq_rotl #(
  parameter int unsigned W    = 32,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] stg [SH_W+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? {stg[s][W-SH-1:0], stg[s][W-1:W-SH]} : stg[s];
  end

  assign data_o = stg[SH_W];

  // rotation never creates or loses ones (R2)
  always_comb begin
    assert_rot_popcount_R2: assert ($countones(data_o) == $countones(data_i));
  end
endmodule

// File: rtl/slq_mask.sv
module slq_mask #(
  parameter int unsigned W    = 32,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  logic [SH_W-1:0] amt_i,
  input  logic            kill_i,
  output logic [W-1:0]    mask_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask_o[i] = !kill_i && (int'(amt_i) <= i);
  end

  always_comb begin
    if (!kill_i)
      assert_mask_low_zero_R3: assert ($countones(mask_o) == W - int'(amt_i));
  end
endmodule

// File: rtl/slq_unit.sv
module slq_unit
  import slq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [DATA_W-1:0]   rs_val_i,
  input  logic [DATA_W-1:0]   rb_val_i,
  input  logic                sum_ovf_i,
  output logic [IDX_W-1:0]    rs_idx_o,
  output logic [IDX_W-1:0]    rb_idx_o,
  output logic                ra_we_o,
  output logic [IDX_W-1:0]    ra_idx_o,
  output logic [DATA_W-1:0]   ra_data_o,
  output logic [DATA_W-1:0]   mq_o,
  output logic                cr0_we_o,
  output logic [CR_W-1:0]     cr0_o
);
  dec_t              dec;
  logic              fire;
  logic [SH_W-1:0]   amt;
  logic              kill;
  logic [DATA_W-1:0] rot;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] res;
  logic [CR_W-1:0]   cr_nxt;
  logic              unused_rb_hi;

  slq_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign rs_idx_o     = dec.src_idx;
  assign rb_idx_o     = dec.ctl_idx;
  assign fire         = valid_i && dec.hit;
  assign amt          = rb_val_i[SH_W-1:0];
  assign kill         = rb_val_i[SH_W];
  assign unused_rb_hi = ^rb_val_i[DATA_W-1:SH_W+1];

  slq_rotl #(.W(DATA_W)) u_rot (.data_i(rs_val_i), .amt_i(amt), .data_o(rot));
  slq_mask #(.W(DATA_W)) u_msk (.amt_i(amt), .kill_i(kill), .mask_o(mask));

  assign res = rot & mask;

  always_comb begin
    cr_nxt[3] = res[DATA_W-1];
    cr_nxt[2] = !res[DATA_W-1] && (res != '0);
    cr_nxt[1] = (res == '0);
    cr_nxt[0] = sum_ovf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_we_o   <= 1'b0;
      ra_idx_o  <= '0;
      ra_data_o <= '0;
      mq_o      <= '0;
      cr0_we_o  <= 1'b0;
      cr0_o     <= '0;
    end else begin
      ra_we_o  <= fire;
      cr0_we_o <= fire && dec.rec;
      if (fire) begin
        ra_idx_o  <= dec.dst_idx;
        ra_data_o <= res;
        mq_o      <= rot;
        if (dec.rec) cr0_o <= cr_nxt;
      end
    end
  end

  assert_we_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_we_o |-> $past(valid_i && instr_i[31:26] == 6'd31 && instr_i[10:1] == 10'd152));
  assert_mq_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ra_we_o |-> $stable(mq_o));
  assert_kill_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && rb_val_i[SH_W]) |=> (ra_we_o && ra_data_o == '0));
  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_we_o && !$past(valid_i) |-> 1'b0);
  assert_cr0_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr0_we_o |-> ($countones(cr0_o[3:1]) == 1 && cr0_o[1] == (ra_data_o == '0)));
  assert_cr0_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr0_we_o |-> (cr0_o[3] == ra_data_o[DATA_W-1]));
  assert_cr0_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr0_we_o |-> $stable(cr0_o));
  assert_cr0_needs_ra_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr0_we_o |-> ra_we_o);
endmodule

// File: tb/slq_unit_bench.sv
`timescale 1ns/1ps
module slq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rb_val = '0;
  logic        so = 1'b0;
  logic [4:0]  rs_idx, rb_idx, ra_idx;
  logic        ra_we, cr0_we;
  logic [31:0] ra_data, mq;
  logic [3:0]  cr0;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_mq = '0;
  logic [3:0]  exp_cr0 = '0;

  always #4 clk = ~clk;

  slq_unit u_slq_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rs_val_i(rs_val), .rb_val_i(rb_val), .sum_ovf_i(so),
    .rs_idx_o(rs_idx), .rb_idx_o(rb_idx), .ra_we_o(ra_we), .ra_idx_o(ra_idx),
    .ra_data_o(ra_data), .mq_o(mq), .cr0_we_o(cr0_we), .cr0_o(cr0)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] s,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [9:0] xo, input logic rc);
    return {op, s, a, b, xo, rc};
  endfunction

  function automatic logic [31:0] m_rot(input logic [31:0] x, input logic [4:0] n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] m_res(input logic [31:0] x, input logic [31:0] b);
    if (b[5]) return 32'h0;
    return m_rot(x, b[4:0]) & (32'hFFFF_FFFF << b[4:0]);
  endfunction

  function automatic logic [3:0] m_cr(input logic [31:0] r, input logic s);
    return {r[31], !r[31] && r != 0, r == 0, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic s);
    logic hit;
    logic [31:0] r;
    hit = ins[31:26] == 6'd31 && ins[10:1] == 10'd152;
    r = m_res(a, b);
    chk("R5 idle", {31'b0, ra_we}, 32'h0);
    instr = ins; rs_val = a; rb_val = b; so = s; valid = 1'b1;
    #1;
    chk("R10 rs_idx", {27'b0, rs_idx}, {27'b0, ins[25:21]});
    chk("R10 rb_idx", {27'b0, rb_idx}, {27'b0, ins[15:11]});
    @(negedge clk);
    valid = 1'b0;
    if (hit) begin
      exp_mq = m_rot(a, b[4:0]);
      if (ins[0]) exp_cr0 = m_cr(r, s);
      chk("R5 ra_we", {31'b0, ra_we}, 32'h1);
      chk("R5 ra_idx", {27'b0, ra_idx}, {27'b0, ins[20:16]});
      chk(b[5] ? "R4 ra_data" : "R3 ra_data", ra_data, r);
      chk(ins[0] ? "R6 cr0_we" : "R7 cr0_we", {31'b0, cr0_we}, {31'b0, ins[0]});
    end else begin
      chk("R1 ra_we", {31'b0, ra_we}, 32'h0);
      chk("R1 cr0_we", {31'b0, cr0_we}, 32'h0);
    end
    chk("R2 mq", mq, exp_mq);
    chk(ins[0] ? "R6 cr0" : "R7 cr0", {28'b0, cr0}, {28'b0, exp_cr0});
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] good, good_rc, r1, r2;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R8 mq", mq, 0);
    chk("R8 cr0", {28'b0, cr0}, 0);
    chk("R8 ra_data", ra_data, 0);
    chk("R8 we", {30'b0, ra_we, cr0_we}, 0);
    chk("R8 ra_idx", {27'b0, ra_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    good    = mk(6'd31, 5'd4, 5'd6, 5'd5, 10'd152, 1'b0);
    good_rc = mk(6'd31, 5'd4, 5'd6, 5'd5, 10'd152, 1'b1);
    // worked examples
    run_op(good, 32'h9000_3000, 32'h0000_0024, 1'b0);
    chk("R2 example mq", mq, 32'h0003_0009);
    chk("R4 example ra", ra_data, 32'h0);
    run_op(good_rc, 32'hB004_3000, 32'h0000_0004, 1'b0);
    chk("R3 example ra", ra_data, 32'h0043_0000);
    chk("R6 example cr0", {28'b0, cr0}, 32'h4);
    // R7: no record bit keeps cr0 = 4
    run_op(good, 32'h8000_0001, 32'h0, 1'b1);
    // R6 negative with SO, zero result
    run_op(good_rc, 32'h8000_0001, 32'h0, 1'b1);
    run_op(good_rc, 32'h1234_5678, 32'h20, 1'b0);
    // shift 31 boundary
    run_op(good_rc, 32'hFFFF_FFFF, 32'h1F, 1'b0);
    // R9 upper rb bits ignored
    run_op(good_rc, 32'hCAFE_F00D, 32'hFFFF_FFC7, 1'b0);
    run_op(good_rc, 32'hCAFE_F00D, 32'hABCD_EF27, 1'b1);
    // R1 bad opcode / bad extended opcode keep state
    run_op(mk(6'd30, 5'd1, 5'd2, 5'd3, 10'd152, 1'b1), 32'h1111_1111, 32'h3, 1'b1);
    run_op(mk(6'd31, 5'd1, 5'd2, 5'd3, 10'd153, 1'b1), 32'h2222_2222, 32'h3, 1'b1);
    run_op(mk(6'd31, 5'd1, 5'd2, 5'd3, 10'd184, 1'b1), 32'h3333_3333, 32'h7, 1'b0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins;
      r1 = $urandom; r2 = $urandom;
      ins = mk(6'd31, 5'($urandom), 5'($urandom), 5'($urandom), 10'd152, 1'($urandom));
      case ($urandom % 8)
        0: ins[31:26] = 6'($urandom);
        1: ins[10:1]  = 10'($urandom);
        default: ;
      endcase
      if ($urandom % 2 == 0) r2 = {26'b0, r2[5:0]};
      run_op(ins, r1, r2, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule